// File: doc/BRIEF.md
# Reference Clock Output Gating and PLL Mode Selection

This block sits beside a clock fan-out buffer and decides, for each buffered output, whether it toggles or is parked low. Every output has its own active-low enable request. A request is taken into the reference clock domain through a synchroniser, and the gate that follows moves only while the reference clock is low. An output therefore starts or stops only on whole pulses, within a short and fixed number of reference cycles after its request changes.

The same block also produces the two mode selects for the PLL: bandwidth (high or low) and bypass (fan-out only). A configuration bit picks the source. In pin mode the bandwidth comes from a board pin and bypass is kept off. In register mode both selects come from register bits. The resolved selects are registered, so a change of source or of value never reaches the PLL as a glitch.

Top module: `refclk_outen_ctl`

## Requirements
- R1: While `rst_n` is low, every `out_active` bit and every `out_clk` are 0, `pll_bw_high` is 1 and `pll_bypass` is 0.
- R2: An `out_en_n` bit at 0 runs its output and an `out_en_n` bit at 1 stops it. During the high phase after rising edge k, `out_active[i]` equals the inverse of `out_en_n[i]` as sampled at rising edge k-2, so the output reacts between 1 and 3 reference cycles after the request changes.
- R3: An `out_active` bit changes only at falling edges of `clk_ref`, never during the high phase, so no shortened `out_clk` pulse appears.
- R4: When `out_active[i]` is 0, `out_clk[i]` stays 0. When it is 1, `out_clk[i]` follows `clk_ref`.
- R5: Each output's gating depends only on its own enable request. Changing one request leaves the other output unaffected.
- R6: In register mode (`cfg_reg_src` = 1 at rising edge k), `pll_bw_high` and `pll_bypass` take `cfg_bw_high` and `cfg_bypass` as sampled at edge k, in the cycle after edge k.
- R7: In pin mode (`cfg_reg_src` = 0 at edge k), `pll_bypass` is 0 after edge k and `cfg_bw_high` and `cfg_bypass` have no effect. `pll_bw_high` takes the value of `bw_pin` sampled at edge k-2 (bw_pin 1 = high bandwidth, 0 = low).
- R8: `pll_bw_high` and `pll_bypass` change only at rising edges of `clk_ref`, including when `cfg_reg_src` switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that is gated to the outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en_n | input | NUM_OUT | Per-output active-low enable request, asynchronous |
| bw_pin | input | 1 | Bandwidth pin, 1 = high bandwidth, asynchronous |
| cfg_reg_src | input | 1 | 1 = mode selects come from register bits, 0 = from pin |
| cfg_bw_high | input | 1 | Register bandwidth bit, 1 = high |
| cfg_bypass | input | 1 | Register bypass bit, 1 = PLL bypassed |
| out_clk | output | NUM_OUT | Gated reference clock per output |
| out_active | output | NUM_OUT | Per-output gate state, 1 = output running |
| pll_bw_high | output | 1 | Resolved bandwidth select |
| pll_bypass | output | 1 | Resolved bypass select |

## Verification
The enable requests are driven four ways: held steady, toggled on one output while the other stays fixed, toggled on every cycle, and switched at random times in both clock phases. Steady and one-sided patterns separate wrong polarity and crosstalk between outputs. Single-cycle toggles and drives in both phases separate a missing or extra synchroniser stage, and a gate that moves during the high phase. For the mode selects, the pin and the register bits are set to opposite values and the source bit is switched back and forth, so a select that reads the wrong source, ignores the source bit, or lets bypass through in pin mode shows a mismatch.

// File: rtl/refclk_outen_pkg.sv
`timescale 1ns/1ps
package refclk_outen_pkg;
   typedef enum logic {
      SRC_PIN = 1'b0,
      SRC_REG = 1'b1
   } mode_src_e;

   typedef struct packed {
      logic bw_high;
      logic bypass;
   } pll_mode_t;

   localparam pll_mode_t MODE_RESET = '{bw_high: 1'b1, bypass: 1'b0};
endpackage

// File: rtl/refclk_sync_chain.sv
`timescale 1ns/1ps
module refclk_sync_chain #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= RST_VAL;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/refclk_gate_cell.sv
`timescale 1ns/1ps
module refclk_gate_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic gate,
   output logic gclk
);
   // The enable is retimed on the falling edge, so it is stable for the whole high phase
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate <= 1'b0;
      else        gate <= run;
   end

   assign gclk = clk & gate;
endmodule

// File: rtl/refclk_mode_resolve.sv
`timescale 1ns/1ps
module refclk_mode_resolve
   import refclk_outen_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  mode_src_e src,
   input  logic      pin_bw_high,
   input  logic      reg_bw_high,
   input  logic      reg_bypass,
   output pll_mode_t mode
);
   pll_mode_t nxt;

   always_comb begin
      unique case (src)
         SRC_REG: nxt = '{bw_high: reg_bw_high, bypass: reg_bypass};
         default: nxt = '{bw_high: pin_bw_high, bypass: 1'b0};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode <= MODE_RESET;
      else        mode <= nxt;
   end
endmodule

// File: rtl/refclk_outen_ctl.sv
`timescale 1ns/1ps
module refclk_outen_ctl
   import refclk_outen_pkg::*;
#(
   parameter int NUM_OUT     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk_ref,
   input  logic               rst_n,
   input  logic [NUM_OUT-1:0] out_en_n,
   input  logic               bw_pin,
   input  logic               cfg_reg_src,
   input  logic               cfg_bw_high,
   input  logic               cfg_bypass,
   output logic [NUM_OUT-1:0] out_clk,
   output logic [NUM_OUT-1:0] out_active,
   output logic               pll_bw_high,
   output logic               pll_bypass
);
   // Worst-case request-to-gate delay in whole cycles, rounded up
   localparam int MAX_LAT_CYC = SYNC_STAGES + 1;

   if (NUM_OUT < 1) begin : g_bad_count
      $error("refclk_outen_ctl: NUM_OUT must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("refclk_outen_ctl: SYNC_STAGES must be at least 2");
   end
   if (MAX_LAT_CYC > 3) begin : g_bad_lat
      $error("refclk_outen_ctl: gating latency would exceed 3 cycles");
   end

   logic [NUM_OUT-1:0] en_n_sync;

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      refclk_sync_chain #(
         .STAGES (SYNC_STAGES),
         .RST_VAL(1'b1)
      ) u_en_sync (
         .clk  (clk_ref),
         .rst_n(rst_n),
         .d    (out_en_n[i]),
         .q    (en_n_sync[i])
      );

      refclk_gate_cell u_gate (
         .clk  (clk_ref),
         .rst_n(rst_n),
         .run  (~en_n_sync[i]),
         .gate (out_active[i]),
         .gclk (out_clk[i])
      );
   end

   logic      bw_pin_sync;
   pll_mode_t mode_q;

   refclk_sync_chain #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(MODE_RESET.bw_high)
   ) u_bw_sync (
      .clk  (clk_ref),
      .rst_n(rst_n),
      .d    (bw_pin),
      .q    (bw_pin_sync)
   );

   refclk_mode_resolve u_mode (
      .clk        (clk_ref),
      .rst_n      (rst_n),
      .src        (mode_src_e'(cfg_reg_src)),
      .pin_bw_high(bw_pin_sync),
      .reg_bw_high(cfg_bw_high),
      .reg_bypass (cfg_bypass),
      .mode       (mode_q)
   );

   assign pll_bw_high = mode_q.bw_high;
   assign pll_bypass  = mode_q.bypass;
endmodule

// File: rtl/refclk_outen_chk.sv
`timescale 1ns/1ps
module refclk_outen_chk #(
   parameter int NUM_OUT = 2
) (
   input logic               clk_ref,
   input logic               rst_n,
   input logic [NUM_OUT-1:0] out_en_n,
   input logic               bw_pin,
   input logic               cfg_reg_src,
   input logic               cfg_bw_high,
   input logic               cfg_bypass,
   input logic [NUM_OUT-1:0] out_active,
   input logic               pll_bw_high,
   input logic               pll_bypass
);
   logic [1:0] age;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)         age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R1
   always @(negedge clk_ref) begin
      if (!rst_n) begin
         rst_state_chk: assert (out_active == '0 && pll_bw_high && !pll_bypass);
      end
   end

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_lat
      // R2
      gate_latency_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
         (age == 2'd3) |-> (out_active[i] == !$past(out_en_n[i], 2)));
   end

   // R6
   reg_mode_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (age != 2'd0 && $past(cfg_reg_src)) |->
         (pll_bw_high == $past(cfg_bw_high) && pll_bypass == $past(cfg_bypass)));

   // R7
   pin_bypass_off_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (age != 2'd0 && !$past(cfg_reg_src)) |-> !pll_bypass);

   // R7
   pin_bw_follow_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (age == 2'd3 && !$past(cfg_reg_src)) |-> (pll_bw_high == $past(bw_pin, 3)));
endmodule

bind refclk_outen_ctl refclk_outen_chk #(.NUM_OUT(NUM_OUT)) u_chk (
   .clk_ref    (clk_ref),
   .rst_n      (rst_n),
   .out_en_n   (out_en_n),
   .bw_pin     (bw_pin),
   .cfg_reg_src(cfg_reg_src),
   .cfg_bw_high(cfg_bw_high),
   .cfg_bypass (cfg_bypass),
   .out_active (out_active),
   .pll_bw_high(pll_bw_high),
   .pll_bypass (pll_bypass)
);

// File: tb/refclk_outen_ctl_tb.sv
`timescale 1ns/100ps
module refclk_outen_ctl_tb;
   localparam int NOUT = 2;

   logic            clk_ref = 1'b0;
   logic            rst_n;
   logic [NOUT-1:0] out_en_n;
   logic            bw_pin, cfg_reg_src, cfg_bw_high, cfg_bypass;
   logic [NOUT-1:0] out_clk, out_active;
   logic            pll_bw_high, pll_bypass;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  live = 0;
   bit  done = 0;

   always #2 clk_ref = ~clk_ref;

   refclk_outen_ctl #(.NUM_OUT(NOUT), .SYNC_STAGES(2)) u_dut (
      .clk_ref(clk_ref), .rst_n(rst_n), .out_en_n(out_en_n), .bw_pin(bw_pin),
      .cfg_reg_src(cfg_reg_src), .cfg_bw_high(cfg_bw_high), .cfg_bypass(cfg_bypass),
      .out_clk(out_clk), .out_active(out_active),
      .pll_bw_high(pll_bw_high), .pll_bypass(pll_bypass)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   // Reference model: request history per rising edge, bit0 = newest sample
   bit [2:0] en_hist [NOUT];
   bit [2:0] bw_hist;
   bit       exp_bw, exp_byp;

   always @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NOUT; i++) en_hist[i] <= 3'b111;
         bw_hist <= 3'b111;
         exp_bw  <= 1'b1;
         exp_byp <= 1'b0;
      end else begin
         for (int i = 0; i < NOUT; i++) en_hist[i] <= {en_hist[i][1:0], out_en_n[i]};
         bw_hist <= {bw_hist[1:0], bw_pin};
         if (cfg_reg_src) begin
            exp_bw  <= cfg_bw_high;
            exp_byp <= cfg_bypass;
         end else begin
            exp_bw  <= bw_hist[1];
            exp_byp <= 1'b0;
         end
      end
   end

   // High-phase checks
   always @(posedge clk_ref) begin
      logic [NOUT-1:0] act_hi;
      logic            bw_hi, byp_hi;
      #0.5;
      if (live) begin
         for (int i = 0; i < NOUT; i++) begin
            chk(out_active[i] == !en_hist[i][2], $sformatf("R2/R5 out%0d high", i), out_active[i], !en_hist[i][2]);
            chk(out_clk[i] == out_active[i], $sformatf("R4 out%0d", i), out_clk[i], out_active[i]);
         end
         chk(pll_bw_high == exp_bw, cfg_reg_src ? "R6 bw" : "R7 bw", pll_bw_high, exp_bw);
         chk(pll_bypass == exp_byp, "R6/R7 bypass", pll_bypass, exp_byp);
      end
      act_hi = out_active; bw_hi = pll_bw_high; byp_hi = pll_bypass;
      #1.0;
      if (live) begin
         chk(out_active == act_hi, "R3 gate stable in high phase", out_active, act_hi);
         chk(out_clk == out_active, "R3 full pulse", out_clk, out_active);
         chk({pll_bw_high, pll_bypass} == {bw_hi, byp_hi}, "R8 selects stable", {pll_bw_high, pll_bypass}, {bw_hi, byp_hi});
      end
   end

   // Low-phase checks
   always @(negedge clk_ref) begin
      #0.5;
      if (live) begin
         for (int i = 0; i < NOUT; i++)
            chk(out_active[i] == !en_hist[i][1], $sformatf("R2/R5 out%0d low", i), out_active[i], !en_hist[i][1]);
         chk(out_clk == '0, "R4 low phase", out_clk, 0);
         chk({pll_bw_high, pll_bypass} == {exp_bw, exp_byp}, "R8 selects low phase", {pll_bw_high, pll_bypass}, {exp_bw, exp_byp});
      end
   end

   task automatic slot(input bit low_phase);
      if (low_phase) @(negedge clk_ref);
      else           @(posedge clk_ref);
      #1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk_ref);
   endtask

   // R2: measure request-to-gate delay in cycles
   task automatic lat_probe(input int i, input bit val_n, input bit low_phase);
      realtime t0, dt;
      bit      seen = 0;
      slot(low_phase);
      out_en_n[i] = val_n;
      t0 = $realtime;
      for (int k = 0; k < 40 && !seen; k++) begin
         #0.5;
         if (out_active[i] == !val_n) seen = 1;
      end
      dt = ($realtime - t0) / 4.0;
      chk(seen && dt >= 1.0 && dt <= 3.0, $sformatf("R2 latency out%0d", i), int'(dt * 10.0), 20);
   endtask

   initial begin
      #(4 * 100000);
      chk(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      rst_n = 1'b1;
      out_en_n = '0; bw_pin = 1'b0;
      cfg_reg_src = 1'b0; cfg_bw_high = 1'b0; cfg_bypass = 1'b1;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk_ref);
      #0.5;
      // R1
      chk(out_active == '0, "R1 gates off", out_active, 0);
      chk(pll_bw_high == 1'b1, "R1 bw high", pll_bw_high, 1);
      chk(pll_bypass == 1'b0, "R1 bypass off", pll_bypass, 0);
      @(posedge clk_ref); #0.5;
      chk(out_clk == '0, "R1 clocks parked", out_clk, 0);
      slot(1);
      rst_n = 1'b1;
      live = 1;
      idle(10);
      chk(out_active == '1, "R2 open requests run", out_active, 3);
      chk(pll_bypass == 1'b0, "R7 register bypass ignored in pin mode", pll_bypass, 0);

      // One output at a time
      lat_probe(0, 1'b1, 1'b0); idle(5);
      chk(out_active[1] == 1'b1, "R5 out1 unaffected", out_active[1], 1);
      lat_probe(0, 1'b0, 1'b1); idle(5);
      lat_probe(1, 1'b1, 1'b1); idle(5);
      chk(out_active[0] == 1'b1, "R5 out0 unaffected", out_active[0], 1);
      lat_probe(1, 1'b0, 1'b0); idle(5);

      // Single-cycle toggles
      for (int k = 0; k < 24; k++) begin
         slot(k[0]);
         out_en_n = k[1] ? 2'b01 : 2'b10;
      end
      out_en_n = '0; idle(5);

      // Pin bandwidth with register bits opposite
      slot(0); bw_pin = 1'b1; cfg_bw_high = 1'b0; cfg_bypass = 1'b1; idle(6);
      chk(pll_bw_high == 1'b1 && pll_bypass == 1'b0, "R7 pin high bw", {pll_bw_high, pll_bypass}, 2);
      slot(1); bw_pin = 1'b0; idle(6);
      chk(pll_bw_high == 1'b0, "R7 pin low bw", pll_bw_high, 0);

      // Register mode
      slot(0); cfg_reg_src = 1'b1; cfg_bw_high = 1'b1; cfg_bypass = 1'b1; idle(3);
      chk(pll_bw_high == 1'b1 && pll_bypass == 1'b1, "R6 register values", {pll_bw_high, pll_bypass}, 3);
      slot(1); bw_pin = 1'b1; cfg_bw_high = 1'b0; cfg_bypass = 1'b0; idle(3);
      chk(pll_bw_high == 1'b0 && pll_bypass == 1'b0, "R6 pin ignored", {pll_bw_high, pll_bypass}, 0);

      // Source switching back and forth
      for (int k = 0; k < 16; k++) begin
         slot(k[0]);
         cfg_reg_src = ~cfg_reg_src;
         cfg_bypass  = k[1];
         idle(k % 3);
      end

      // Random phase
      for (int k = 0; k < 3000; k++) begin
         int r;
         r = $urandom_range(0, 15);
         slot(r[0]);
         if (r < 5)       out_en_n[0] = ~out_en_n[0];
         else if (r < 10) out_en_n[1] = ~out_en_n[1];
         else if (r == 10) bw_pin = ~bw_pin;
         else if (r == 11) cfg_reg_src = ~cfg_reg_src;
         else if (r == 12) cfg_bw_high = ~cfg_bw_high;
         else if (r == 13) cfg_bypass = ~cfg_bypass;
      end
      idle(6);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule